// File: doc/BRIEF.md
# Rectifier Sector Gate Selector

This block generates the gate commands for the six bidirectional switches of a current-source rectifier that feeds one half of a split DC link. An external processor supplies three values: the sector of the input voltage, which is one of six 60-degree sectors, and two duty counts measured in clock cycles. The block samples these values at the start of each sampling period. One switch is chosen from the sector and stays on for the whole period. Two more switches, also chosen from the sector, are modulated one after the other, so the link sees two different line-to-line voltages during the period. No zero current vector is ever applied. The period therefore lasts exactly the sum of the two duty counts.

Each handover from one modulated switch to the other is covered by a programmable dead time, during which both modulated switches are off. The same applies to the handover from the last modulated switch of one period to the first of the next. At the boundary between the two duty slots the block raises a single-cycle strobe, so the inverter stage can enter a freewheeling state while the rectifier commutates. One controller drives several identical gate paths, one per half-link rectifier, so the upper and lower rectifiers always switch together.

Top module: `rect_sector_gate`

## Requirements
- R1: While reset is asserted, every gate and the commutate strobe are low. The first period is loaded at the first clock edge after reset is released, and the outputs stay low for the cycle that follows that edge.
- R2: The sector and duty inputs are sampled only at the edge that starts a period. A period lasts dutyX+dutyY cycles, or one cycle when both counts are zero. Changes to the inputs during a period have no effect until the next period starts. All outputs are registered: the value for period cycle k (k=0 at the loading edge) is visible in the clock cycle after edge k+1.
- R3: Within each 6-bit gate group, bits 0..2 are the upper switches of phases a, b, c and bits 3..5 are the lower switches of phases a, b, c. The switch held on for every cycle of a period, and the first and second modulated switches, are set by the sector. Sector 1: upper-a held on; modulated lower-b, then lower-c. Sector 2: lower-c held on; upper-b, then upper-a. Sector 3: upper-b held on; lower-c, then lower-a. Sector 4: lower-a held on; upper-c, then upper-b. Sector 5: upper-c held on; lower-a, then lower-b. Sector 6: lower-b held on; upper-c, then upper-a.
- R4: The first modulated switch is on for period cycles DEAD_CYC <= k < dutyX. The second is on for dutyX+DEAD_CYC <= k < dutyX+dutyY. Outside these windows both modulated switches are off, while the held switch stays on.
- R5: The commutate strobe is high for exactly one cycle, for period cycle k = dutyX. It is raised only when both duty counts are nonzero and the sector is valid.
- R6: A sampled sector of 0 or 7 turns off all six switches for that whole period, and no commutate strobe is issued.
- R7: All NUM_LINK gate groups carry identical values in every cycle.
- R8: In any gate group, at most one upper switch and at most one lower switch are on at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sector | input | 3 | Input-voltage sector, 1..6 valid |
| dutyX | input | DUTY_W | Cycles of the first duty slot |
| dutyY | input | DUTY_W | Cycles of the second duty slot |
| linkGates | output | 6*NUM_LINK | Gate commands, 6 bits per half-link rectifier |
| commute | output | 1 | One-cycle strobe at the handover between the two duty slots |

## Verification
The bench targets duty slots that are shorter than the dead time, zero-length slots on either side, and a period in which both counts are zero. A design that measured dead time from the wrong point would let a modulated switch start on top of its predecessor. A design that mishandled an empty slot would either strobe with no handover or miss the strobe. The bench also changes the inputs in the middle of a period. A design that failed to hold the sampled values would then change the switch pattern early or cut the period short. Invalid sector codes are interleaved with valid ones, so that a decoder defaulting to some sector would be caught leaving a switch on.

// File: rtl/rect_gate_pkg.sv
package rect_gate_pkg;

  localparam int SW_COUNT = 6;

  typedef logic [2:0] sector_t;

  typedef struct packed {
    sector_t sector;
    logic    fixedOn;
    logic    modXOn;
    logic    modYOn;
  } gateStrobe_t;

  typedef struct packed {
    logic [2:0] fixIdx;
    logic [2:0] xIdx;
    logic [2:0] yIdx;
    logic       valid;
  } sectorMap_t;

  // switch index: 0..2 upper a,b,c ; 3..5 lower a,b,c
  function automatic sectorMap_t mapSector(sector_t s);
    sectorMap_t m;
    m = '{fixIdx: 3'd0, xIdx: 3'd0, yIdx: 3'd0, valid: 1'b0};
    case (s)
      3'd1: m = '{fixIdx: 3'd0, xIdx: 3'd4, yIdx: 3'd5, valid: 1'b1};
      3'd2: m = '{fixIdx: 3'd5, xIdx: 3'd1, yIdx: 3'd0, valid: 1'b1};
      3'd3: m = '{fixIdx: 3'd1, xIdx: 3'd5, yIdx: 3'd3, valid: 1'b1};
      3'd4: m = '{fixIdx: 3'd3, xIdx: 3'd2, yIdx: 3'd1, valid: 1'b1};
      3'd5: m = '{fixIdx: 3'd2, xIdx: 3'd3, yIdx: 3'd4, valid: 1'b1};
      3'd6: m = '{fixIdx: 3'd4, xIdx: 3'd2, yIdx: 3'd0, valid: 1'b1};
      default: m = '{fixIdx: 3'd0, xIdx: 3'd0, yIdx: 3'd0, valid: 1'b0};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rect_gate_ctrl.sv
module rect_gate_ctrl
  import rect_gate_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int DEAD_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        sector,
  input  logic [DUTY_W-1:0] dutyX,
  input  logic [DUTY_W-1:0] dutyY,
  output gateStrobe_t       strobes,
  output logic              commute
);

  localparam int CNT_W = DUTY_W + 2;
  localparam logic [CNT_W-1:0] DEAD_E = CNT_W'(DEAD_CYC);

  logic              running;
  logic [CNT_W-1:0]  cnt;
  sector_t           sectorQ;
  logic [DUTY_W-1:0] dxQ;
  logic [DUTY_W-1:0] dyQ;

  logic [CNT_W-1:0]  dxE;
  logic [CNT_W-1:0]  lenSum;
  logic              lastCyc;
  logic              validNow;
  logic              commNext;

  always_comb begin
    dxE      = CNT_W'(dxQ);
    lenSum   = dxE + CNT_W'(dyQ);
    lastCyc  = (lenSum == '0) || (cnt == lenSum - CNT_W'(1));
    validNow = running && (sectorQ != 3'd0) && (sectorQ != 3'd7);
  end

  always_comb begin
    strobes.sector  = sectorQ;
    strobes.fixedOn = validNow;
    strobes.modXOn  = validNow && (cnt >= DEAD_E) && (cnt < dxE);
    strobes.modYOn  = validNow && (cnt >= dxE + DEAD_E) && (cnt < lenSum);
    commNext        = validNow && (dxQ != '0) && (dyQ != '0) && (cnt == dxE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      sectorQ <= '0;
      dxQ     <= '0;
      dyQ     <= '0;
      commute <= 1'b0;
    end else begin
      commute <= commNext;
      if (!running || lastCyc) begin
        running <= 1'b1;
        cnt     <= '0;
        sectorQ <= sector;
        dxQ     <= dutyX;
        dyQ     <= dutyY;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rect_gate_path.sv
module rect_gate_path
  import rect_gate_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  gateStrobe_t         strobes,
  output logic [SW_COUNT-1:0] gates
);

  sectorMap_t          map;
  logic [SW_COUNT-1:0] gateNext;

  always_comb begin
    map      = mapSector(strobes.sector);
    gateNext = '0;
    if (map.valid) begin
      if (strobes.fixedOn) gateNext[map.fixIdx] = 1'b1;
      if (strobes.modXOn)  gateNext[map.xIdx]   = 1'b1;
      if (strobes.modYOn)  gateNext[map.yIdx]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) gates <= '0;
    else       gates <= gateNext;
  end

endmodule

// File: rtl/rect_sector_gate.sv
module rect_sector_gate
  import rect_gate_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int DEAD_CYC = 8,
  parameter int NUM_LINK = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2:0]                   sector,
  input  logic [DUTY_W-1:0]            dutyX,
  input  logic [DUTY_W-1:0]            dutyY,
  output logic [SW_COUNT*NUM_LINK-1:0] linkGates,
  output logic                         commute
);

  gateStrobe_t stb;

  rect_gate_ctrl #(.DUTY_W(DUTY_W), .DEAD_CYC(DEAD_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sector  (sector),
    .dutyX   (dutyX),
    .dutyY   (dutyY),
    .strobes (stb),
    .commute (commute)
  );

  for (genvar l = 0; l < NUM_LINK; l++) begin : g_link
    rect_gate_path u_path (
      .clk     (clk),
      .rstN    (rstN),
      .strobes (stb),
      .gates   (linkGates[l*SW_COUNT +: SW_COUNT])
    );
  end

endmodule

// File: rtl/rect_gate_checker.sv
module rect_gate_checker #(
  parameter int DEAD_CYC = 8,
  parameter int NUM_LINK = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [6*NUM_LINK-1:0] linkGates,
  input logic                  commute
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (linkGates == '0 && !commute)); // R1

  AST_COMM_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    commute |=> !commute); // R5

  if (DEAD_CYC > 0) begin : g_blank
    AST_COMM_BLANK: assert property (@(posedge clk) disable iff (!rstN)
      commute |-> ($countones(linkGates[5:0]) <= 1)); // R4
  end

  for (genvar l = 0; l < NUM_LINK; l++) begin : g_chk
    AST_SIDE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
      ($countones(linkGates[l*6 +: 3]) <= 1) &&
      ($countones(linkGates[l*6+3 +: 3]) <= 1)); // R8
    AST_LINKS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      linkGates[l*6 +: 6] == linkGates[5:0]); // R7
  end

endmodule

bind rect_sector_gate rect_gate_checker #(.DEAD_CYC(DEAD_CYC), .NUM_LINK(NUM_LINK)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .linkGates (linkGates),
  .commute   (commute)
);

// File: tb/test_rect_sector_gate.sv
module test_rect_sector_gate;

  localparam int DUTY_W   = 8;
  localparam int DEAD_CYC = 8;
  localparam int NUM_LINK = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        sector = 3'd0;
  logic [DUTY_W-1:0] dutyX = '0;
  logic [DUTY_W-1:0] dutyY = '0;
  logic [6*NUM_LINK-1:0] linkGates;
  logic              commute;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rect_sector_gate #(.DUTY_W(DUTY_W), .DEAD_CYC(DEAD_CYC), .NUM_LINK(NUM_LINK))
    i_rect_sector_gate (
      .clk(clk), .rstN(rstN), .sector(sector), .dutyX(dutyX), .dutyY(dutyY),
      .linkGates(linkGates), .commute(commute));

  // requirement table: returns {fixed, first, second} switch indices, -1 if invalid
  function automatic int swIdx(int sec, int which);
    int t[6][3] = '{'{0,4,5}, '{5,1,0}, '{1,5,3}, '{3,2,1}, '{2,3,4}, '{4,2,0}};
    if (sec < 1 || sec > 6) return -1;
    return t[sec-1][which];
  endfunction

  function automatic logic [5:0] gatesFor(int sec, int dx, int dy, int k);
    logic [5:0] g = '0;
    if (swIdx(sec, 0) < 0) return g;
    g[swIdx(sec, 0)] = 1'b1;
    if (k >= DEAD_CYC && k < dx) g[swIdx(sec, 1)] = 1'b1;
    if (k >= dx + DEAD_CYC && k < dx + dy) g[swIdx(sec, 2)] = 1'b1;
    return g;
  endfunction

  // bench model state
  bit         mRun = 0;
  int         mSec = 0, mDx = 0, mDy = 0, mK = 0;
  bit         mChanged = 0;
  logic [5:0] expG = '0;
  logic       expC = 1'b0;
  string      expReq = "R1";

  always @(posedge clk) begin
    int len;
    if (!rstN) begin
      mRun = 0; expG = '0; expC = 1'b0; expReq = "R1";
    end else begin
      if (mRun) begin
        expG = gatesFor(mSec, mDx, mDy, mK);
        expC = (swIdx(mSec, 0) >= 0) && mDx > 0 && mDy > 0 && mK == mDx;
        len  = mDx + mDy;
        if (swIdx(mSec, 0) < 0) expReq = "R6";
        else if ((mK < DEAD_CYC && mK < mDx) ||
                 (mK >= mDx && mK < mDx + DEAD_CYC && mK < len)) expReq = "R4";
        else if (mChanged) expReq = "R2";
        else expReq = "R3";
      end else begin
        expG = '0; expC = 1'b0; expReq = "R1";
      end
      len = mDx + mDy;
      if (!mRun || len == 0 || mK == len - 1) begin
        mRun = 1; mSec = int'(sector); mDx = int'(dutyX); mDy = int'(dutyY);
        mK = 0; mChanged = 0;
      end else begin
        mK++;
        if (int'(sector) != mSec || int'(dutyX) != mDx || int'(dutyY) != mDy)
          mChanged = 1;
      end
    end
  end

  task automatic checkNow();
    checks++;
    if (linkGates[5:0] !== expG) begin
      errors++;
      $display("FAIL %s gates actual=%b expected=%b t=%0t", expReq, linkGates[5:0], expG, $time);
    end
    checks++;
    if (commute !== expC) begin
      errors++;
      $display("FAIL R5 commute actual=%b expected=%b t=%0t", commute, expC, $time);
    end
    for (int l = 1; l < NUM_LINK; l++) begin
      checks++;
      if (linkGates[l*6 +: 6] !== linkGates[5:0]) begin
        errors++;
        $display("FAIL R7 link%0d actual=%b expected=%b", l, linkGates[l*6 +: 6], linkGates[5:0]);
      end
    end
    checks++;
    if ($countones(linkGates[2:0]) > 1 || $countones(linkGates[5:3]) > 1) begin
      errors++;
      $display("FAIL R8 gates actual=%b expected=at most one per side", linkGates[5:0]);
    end
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow();
    end
  endtask

  task automatic setIn(int s, int dx, int dy);
    sector = 3'(s); dutyX = DUTY_W'(dx); dutyY = DUTY_W'(dy);
  endtask

  initial begin
    void'($urandom(32'd1234));
    setIn(1, 20, 20);
    rstN = 1'b0;
    runCycles(4);               // R1 reset state
    rstN = 1'b1;
    runCycles(100);             // R3 R4 R5 sector 1
    for (int s = 1; s <= 6; s++) begin
      setIn(s, 12, 14);
      runCycles(60);            // R3 each sector
    end
    setIn(4, 0, 15);  runCycles(50);   // R5 no strobe with empty first slot
    setIn(3, 5, 3);   runCycles(40);   // R4 slots shorter than dead time
    setIn(2, 0, 0);   runCycles(10);   // R2 one-cycle period
    setIn(5, 14, 0);  runCycles(40);   // R5 empty second slot
    setIn(0, 10, 10); runCycles(45);   // R6
    setIn(7, 9, 11);  runCycles(45);   // R6
    setIn(6, 30, 30);
    runCycles(10);
    setIn(0, 2, 2);   runCycles(5);    // R2 mid-period change ignored
    setIn(6, 30, 30); runCycles(80);
    for (int it = 0; it < 400; it++) begin
      int s, dx, dy;
      s  = int'($urandom_range(7, 0));
      dx = (($urandom_range(9, 0)) == 0) ? int'($urandom_range(255, 0)) : int'($urandom_range(30, 0));
      dy = (($urandom_range(9, 0)) == 0) ? int'($urandom_range(255, 0)) : int'($urandom_range(30, 0));
      setIn(s, dx, dy);
      runCycles(int'($urandom_range(60, 1)));
    end
    rstN = 1'b0;
    runCycles(3);               // R1 reset mid-run
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule